// File: doc/BRIEF.md
# Dual-Family Hash Message Padder

This block sits in front of a hash compression core and turns a raw message byte stream into the padded stream that the core consumes. One mode input chooses between the family that works on 64-byte blocks and the family that works on 128-byte blocks. Message bytes pass through unchanged. After the final byte the block appends a single marker byte, then zero bytes up to the length field, then the total message length in bits, most significant byte first. The length field is 8 bytes wide in the narrow family and 16 bytes wide in the wide family.

A message can be hashed in several segments. A 128-bit preload input gives the number of bytes already hashed before this segment. The block samples the preload and the mode on the first accepted beat of a message. It keeps a 128-bit running byte count, built from two 64-bit halves with a carry between them. Block positions and the length field are both measured from the preload base. An input beat that is flagged as carrying no byte can close a message, so an empty message still gets padded.

The controller is a five-state machine:
- **S_IDLE** waits for a first beat. A byte beat moves it to S_MSG. A last beat moves it to S_MARK.
- **S_MSG** passes bytes through. A last beat moves it to S_MARK.
- **S_MARK** emits the marker byte. It moves to S_ZERO, or to S_LEN when the pad is one byte long.
- **S_ZERO** emits zero bytes until its count runs out, then moves to S_LEN.
- **S_LEN** emits the length bytes and returns to S_IDLE after the last one.

Top module: `hash_pad_stream`

## Requirements
- R1: After reset, out_valid and out_final are low, the machine waits for a new message, and in_ready equals out_ready.
- R2: Message bytes appear on out_data unchanged and in order. While a message is being accepted, a byte beat is accepted exactly when out_ready is high.
- R3: The output byte directly after the last message byte has the value 0x80.
- R4: In narrow mode (mode_wide=0), let idx be the total byte count mod 64. The marker plus the zeros is 56−idx bytes when idx<56, and 120−idx bytes otherwise.
- R5: In wide mode (mode_wide=1), let idx be the total byte count mod 128. The marker plus the zeros is 112−idx bytes when idx<112, and 240−idx bytes otherwise.
- R6: The length field is the total byte count times 8, sent most significant byte first. Only the low 64 bits are sent in narrow mode (8 bytes); all 128 bits are sent in wide mode (16 bytes).
- R7: The total byte count is preload_cnt plus the message bytes. It is a 128-bit sum, and the low 64-bit half carries into the high half.
- R8: A beat with in_void=1 and in_last=1 carries no byte and closes the message. An empty message produces exactly one full padded block.
- R9: out_blk_end is high on each output byte whose stream position, counted from preload_cnt, is one less than a multiple of the block size. out_final is high only on the last length byte, and out_blk_end is high there too.
- R10: in_ready is low while marker, zero and length bytes are emitted. While out_ready is low, out_valid and out_data hold.
- R11: mode_wide and preload_cnt are sampled only on the first accepted beat of a message. Later changes have no effect on that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wide | input | 1 | 0: 64-byte blocks, 1: 128-byte blocks |
| preload_cnt | input | 128 | Bytes hashed in earlier segments |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Beat closes the message |
| in_void | input | 1 | Beat carries no byte |
| in_ready | output | 1 | Input beat accepted |
| out_data | output | 8 | Padded stream byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer accepts the byte |
| out_blk_end | output | 1 | Last byte of a block |
| out_final | output | 1 | Last byte of the padded stream |

## Verification
Each fault shows up at the ports within one padded message:
- **Wrong byte count or missing carry** corrupts the length bytes. It also moves the pad length, which shifts out_final away from a block boundary.
- **Wrong stream index** shows up immediately as a misplaced out_blk_end on the next block end.
- **Wrong zero counter or wrong state** either emits the wrong number of zeros or holds in_ready low into the next message.

A reference model in the bench predicts every output byte and flag. Backpressure is random, and the bench perturbs mode_wide and preload_cnt in the middle of a message.

// File: rtl/hpad_pkg.sv
package hpad_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_MSG  = 3'd1,
        S_MARK = 3'd2,
        S_ZERO = 3'd3,
        S_LEN  = 3'd4
    } hpad_state_e;

    localparam logic [7:0] PAD_MARK = 8'h80;
endpackage

// File: rtl/hpad_byte_counter.sv
module hpad_byte_counter #(
    parameter int HALF_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [2*HALF_W-1:0]   load_val,
    input  logic                  inc,
    output logic [2*HALF_W-1:0]   cnt
);
    localparam int CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] base_lo, base_hi, lo_n, hi_n;
    logic [HALF_W:0]   lo_sum;

    always_comb begin
        base_lo = load ? load_val[HALF_W-1:0]     : cnt_q[HALF_W-1:0];
        base_hi = load ? load_val[CNT_W-1:HALF_W] : cnt_q[CNT_W-1:HALF_W];
        lo_sum  = {1'b0, base_lo} + {{HALF_W{1'b0}}, inc};
        lo_n    = lo_sum[HALF_W-1:0];
        hi_n    = base_hi + {{(HALF_W-1){1'b0}}, lo_sum[HALF_W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load || inc)
            cnt_q <= {hi_n, lo_n};
    end

    assign cnt = cnt_q;

    // R7: a full low half that is incremented wraps to zero and carries into the high half
    assert_low_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && (&cnt_q[HALF_W-1:0])) |=>
        (cnt_q[HALF_W-1:0] == '0) &&
        (cnt_q[CNT_W-1:HALF_W] == $past(cnt_q[CNT_W-1:HALF_W]) + 1'b1));
endmodule

// File: rtl/hpad_pad_len.sv
module hpad_pad_len #(
    parameter int NARROW_BLK = 64,
    parameter int WIDE_BLK   = 128,
    parameter int NARROW_LEN = 8,
    parameter int WIDE_LEN   = 16
) (
    input  logic                          wide,
    input  logic [$clog2(WIDE_BLK)-1:0]   idx,
    output logic [$clog2(2*WIDE_BLK)-1:0] pad_len
);
    localparam int PAD_W = $clog2(2 * WIDE_BLK);

    int blk, lfld, pos, pad;

    always_comb begin
        blk  = wide ? WIDE_BLK : NARROW_BLK;
        lfld = wide ? WIDE_LEN : NARROW_LEN;
        pos  = int'(idx) & (blk - 1);
        if (pos < blk - lfld)
            pad = blk - lfld - pos;
        else
            pad = 2 * blk - lfld - pos;
        pad_len = PAD_W'(pad);
    end
endmodule

// File: rtl/hpad_len_byte.sv
module hpad_len_byte #(
    parameter int HALF_W = 64
) (
    input  logic [2*HALF_W-1:0]            cnt,
    input  logic [$clog2(2*HALF_W/8)-1:0]  sel,
    output logic [7:0]                     byte_o
);
    localparam int CNT_W = 2 * HALF_W;
    localparam int NB    = CNT_W / 8;

    logic [CNT_W-1:0] bitlen;
    logic [7:0]       bytes_a [NB];

    assign bitlen = cnt << 3;

    for (genvar g = 0; g < NB; g++) begin : g_bytes
        assign bytes_a[g] = bitlen[g*8 +: 8];
    end

    assign byte_o = bytes_a[sel];
endmodule

// File: rtl/hash_pad_stream.sv
module hash_pad_stream #(
    parameter int HALF_W     = 64,
    parameter int NARROW_BLK = 64,
    parameter int WIDE_BLK   = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wide,
    input  logic [2*HALF_W-1:0] preload_cnt,
    input  logic [7:0]          in_data,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic                in_void,
    output logic                in_ready,
    output logic [7:0]          out_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_blk_end,
    output logic                out_final
);
    import hpad_pkg::*;

    localparam int CNT_W      = 2 * HALF_W;
    localparam int NARROW_LEN = HALF_W / 8;
    localparam int WIDE_LEN   = CNT_W / 8;
    localparam int IDX_W      = $clog2(WIDE_BLK);
    localparam int PAD_W      = $clog2(2 * WIDE_BLK);
    localparam int LSEL_W     = $clog2(WIDE_LEN);

    hpad_state_e       state_q, state_d;
    logic              wide_q, wide_d;
    logic [IDX_W-1:0]  sidx_q, sidx_d;
    logic [PAD_W-1:0]  zcnt_q, zcnt_d;
    logic [LSEL_W-1:0] lsel_q, lsel_d;

    logic              first, passing, wide_eff;
    logic [IDX_W-1:0]  cur_idx, blk_mask;
    logic              in_hs, out_hs, byte_acc;
    logic [PAD_W-1:0]  pad_len;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        len_byte;
    logic [LSEL_W-1:0] lsel_start;

    assign first      = (state_q == S_IDLE);
    assign passing    = (state_q == S_IDLE) || (state_q == S_MSG);
    assign wide_eff   = first ? mode_wide : wide_q;
    assign cur_idx    = first ? preload_cnt[IDX_W-1:0] : sidx_q;
    assign blk_mask   = wide_eff ? IDX_W'(WIDE_BLK - 1) : IDX_W'(NARROW_BLK - 1);
    assign in_hs      = in_valid && in_ready;
    assign out_hs     = out_valid && out_ready;
    assign byte_acc   = passing && in_hs && !in_void;
    assign lsel_start = wide_q ? LSEL_W'(WIDE_LEN - 1) : LSEL_W'(NARROW_LEN - 1);

    hpad_byte_counter #(.HALF_W(HALF_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (first && in_hs),
        .load_val (preload_cnt),
        .inc      (byte_acc),
        .cnt      (cnt)
    );

    hpad_pad_len #(
        .NARROW_BLK (NARROW_BLK),
        .WIDE_BLK   (WIDE_BLK),
        .NARROW_LEN (NARROW_LEN),
        .WIDE_LEN   (WIDE_LEN)
    ) u_padlen (
        .wide    (wide_q),
        .idx     (sidx_q),
        .pad_len (pad_len)
    );

    hpad_len_byte #(.HALF_W(HALF_W)) u_lenbyte (
        .cnt    (cnt),
        .sel    (lsel_q),
        .byte_o (len_byte)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wide_q  <= 1'b0;
            sidx_q  <= '0;
            zcnt_q  <= '0;
            lsel_q  <= '0;
        end else begin
            state_q <= state_d;
            wide_q  <= wide_d;
            sidx_q  <= sidx_d;
            zcnt_q  <= zcnt_d;
            lsel_q  <= lsel_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        wide_d  = wide_q;
        sidx_d  = sidx_q;
        zcnt_d  = zcnt_q;
        lsel_d  = lsel_q;
        unique case (state_q)
            S_IDLE: begin
                if (in_hs) begin
                    wide_d = mode_wide;
                    sidx_d = cur_idx + IDX_W'(byte_acc);
                    if (in_last)
                        state_d = S_MARK;
                    else if (!in_void)
                        state_d = S_MSG;
                end
            end
            S_MSG: begin
                if (in_hs) begin
                    sidx_d = cur_idx + IDX_W'(byte_acc);
                    if (in_last)
                        state_d = S_MARK;
                end
            end
            S_MARK: begin
                if (out_hs) begin
                    sidx_d = sidx_q + 1'b1;
                    if (pad_len == PAD_W'(1)) begin
                        state_d = S_LEN;
                        lsel_d  = lsel_start;
                    end else begin
                        state_d = S_ZERO;
                        zcnt_d  = pad_len - PAD_W'(2);
                    end
                end
            end
            S_ZERO: begin
                if (out_hs) begin
                    sidx_d = sidx_q + 1'b1;
                    if (zcnt_q == '0) begin
                        state_d = S_LEN;
                        lsel_d  = lsel_start;
                    end else begin
                        zcnt_d = zcnt_q - 1'b1;
                    end
                end
            end
            S_LEN: begin
                if (out_hs) begin
                    sidx_d = sidx_q + 1'b1;
                    if (lsel_q == '0)
                        state_d = S_IDLE;
                    else
                        lsel_d = lsel_q - 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready    = 1'b0;
        out_valid   = 1'b0;
        out_data    = 8'h00;
        out_final   = 1'b0;
        out_blk_end = ((cur_idx & blk_mask) == blk_mask);
        unique case (state_q)
            S_IDLE, S_MSG: begin
                in_ready  = in_void ? 1'b1 : out_ready;
                out_valid = in_valid && !in_void;
                out_data  = in_data;
            end
            S_MARK: begin
                out_valid = 1'b1;
                out_data  = PAD_MARK;
            end
            S_ZERO: begin
                out_valid = 1'b1;
            end
            S_LEN: begin
                out_valid = 1'b1;
                out_data  = len_byte;
                out_final = (lsel_q == '0);
            end
            default: ;
        endcase
    end

    // R3: an accepted last beat is always followed by the marker state
    assert_mark_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (passing && in_hs && in_last) |=> (state_q == S_MARK));

    // R4: the pad length stays in its legal range when the marker is emitted
    assert_padlen_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MARK) |->
        (pad_len >= PAD_W'(1)) && (pad_len <= PAD_W'(2*WIDE_BLK - WIDE_LEN)));

    // R9: the final byte always closes a block
    assert_final_blkend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_final) |-> out_blk_end);

    // R10: no input is taken while padding
    assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_MARK, S_ZERO, S_LEN}) |-> !in_ready);

    // R10: a stalled pad byte holds
    assert_pad_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q inside {S_MARK, S_ZERO, S_LEN}) && out_valid && !out_ready) |=>
        (out_valid && $stable(out_data)));

    // R11: the mode is frozen outside the idle state
    assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(wide_q));
endmodule

// File: tb/hash_pad_stream_bench.sv
module hash_pad_stream_bench;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         mode_wide;
    logic [127:0] preload_cnt;
    logic [7:0]   in_data;
    logic         in_valid, in_last, in_void, in_ready;
    logic [7:0]   out_data;
    logic         out_valid, out_ready, out_blk_end, out_final;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_data [0:511];
    logic       exp_be   [0:511];
    logic       exp_fin  [0:511];
    string      exp_tag  [0:511];
    logic [7:0] msg      [0:255];

    always #(PER/2) clk = ~clk;

    hash_pad_stream u_hash_pad_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wide   (mode_wide),
        .preload_cnt (preload_cnt),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_void     (in_void),
        .in_ready    (in_ready),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_blk_end (out_blk_end),
        .out_final   (out_final)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pad_of(input bit wide, input logic [127:0] tot);
        int blk = wide ? 128 : 64;
        int lb  = wide ? 16 : 8;
        int idx = int'(tot[6:0]) % blk;
        return (idx < blk - lb) ? blk - lb - idx : 2 * blk - lb - idx;
    endfunction

    task automatic run_case(input bit wide, input logic [127:0] pre, input int len, input bit void_end);
        int blk, lb, pad, n_exp, n_in, ip, op, cyc, j;
        logic [127:0] tot, bits;
        bit prev_stall;
        logic [7:0] prev_data;
        blk = wide ? 128 : 64;
        lb  = wide ? 16 : 8;
        for (int k = 0; k < len; k++) msg[k] = 8'($urandom);
        tot   = pre + 128'(len);
        bits  = tot << 3;
        pad   = pad_of(wide, tot);
        n_exp = len + pad + lb;
        for (int k = 0; k < n_exp; k++) begin
            exp_be[k]  = ((int'(pre[6:0]) + k) % blk) == blk - 1;
            exp_fin[k] = (k == n_exp - 1);
            if (k < len) begin
                exp_data[k] = msg[k]; exp_tag[k] = "R2";
            end else if (k == len) begin
                exp_data[k] = 8'h80; exp_tag[k] = "R3";
            end else if (k < len + pad) begin
                exp_data[k] = 8'h00; exp_tag[k] = wide ? "R5" : "R4";
            end else begin
                j = k - (len + pad);
                exp_data[k] = bits[(lb-1-j)*8 +: 8];
                exp_tag[k]  = "R6 R7 R11";
            end
        end
        n_in = (void_end || len == 0) ? len + 1 : len;
        ip = 0; op = 0; cyc = 0; prev_stall = 0; prev_data = '0;
        while (op < n_exp && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            out_ready = ($urandom % 4) != 0;
            if (ip > 0) begin
                mode_wide   = 1'($urandom);
                preload_cnt = {$urandom, $urandom, $urandom, $urandom};
            end else begin
                mode_wide   = wide;
                preload_cnt = pre;
            end
            if (ip < n_in) begin
                in_valid = ($urandom % 3) != 0;
                in_void  = (ip == len);
                in_data  = (ip == len) ? 8'($urandom) : msg[ip];
                in_last  = (ip == n_in - 1);
            end else begin
                in_valid = 0; in_void = 0; in_last = 0;
            end
            #1;
            if (ip == n_in && op >= len && op < n_exp)
                chk(!in_ready, "R10 in_ready during pad", in_ready, 0);
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R10 hold under stall", out_data, prev_data);
            prev_stall = (ip == n_in) && out_valid && !out_ready;
            prev_data  = out_data;
            if (in_valid && in_ready) ip++;
            if (out_valid && out_ready) begin
                chk(out_data == exp_data[op], exp_tag[op], out_data, exp_data[op]);
                chk(out_blk_end == exp_be[op], "R9 blk_end", out_blk_end, exp_be[op]);
                chk(out_final == exp_fin[op], "R9 final", out_final, exp_fin[op]);
                op++;
            end
        end
        chk(op == n_exp, "R8 stream completes", op, n_exp);
        if (len == 0)
            chk(n_exp == blk, "R8 empty message is one block", n_exp, blk);
        @(negedge clk);
        in_valid = 0; in_last = 0; in_void = 0;
    endtask

    initial begin
        #(PER * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; in_valid = 0; in_last = 0; in_void = 0; in_data = 0;
        mode_wide = 0; preload_cnt = '0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(!out_valid && !out_final, "R1 outputs idle", {out_valid, out_final}, 0);
        chk(in_ready == out_ready, "R1 ready follows", in_ready, out_ready);

        // R8: empty messages in both families
        run_case(0, 128'd0, 0, 1);
        run_case(1, 128'd0, 0, 1);
        // R4: narrow boundaries around 56
        run_case(0, 128'd0, 55, 0);
        run_case(0, 128'd0, 56, 0);
        run_case(0, 128'd0, 63, 0);
        run_case(0, 128'd0, 64, 1);
        // R5: wide boundaries around 112
        run_case(1, 128'd0, 111, 0);
        run_case(1, 128'd0, 112, 0);
        run_case(1, 128'd0, 127, 1);
        // R7: low-half carry with preload
        run_case(0, {64'd0, 64'hFFFF_FFFF_FFFF_FFFB}, 10, 0);
        run_case(1, {64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFF0}, 40, 0);
        run_case(0, 128'd64000, 20, 0);
        for (int n = 0; n < 10; n++)
            run_case(1'($urandom), {$urandom, $urandom, $urandom, $urandom},
                     int'($urandom % 201), 1'($urandom));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule